// File: doc/BRIEF.md
# Byte-Word Data Memory Access Unit

This block connects the load/store path of a 16-bit processor core to a data RAM built as two byte-wide lanes. The lanes share one word address and have separate write enables. Each request carries an address, a byte-or-word size flag, a read or write command, write data and an extension mode. The block steers bytes to the correct lane and drives the per-lane write strobes. It returns read data already merged into the destination register value, and it computes the post-incremented pointer.

A word access must use an even address. A word access to an odd address raises an address-error trap. For a read, the access still completes and returns data first. For a write, no lane is written. The effective address of the first fault is held for inspection until the core clears it. The low 2 KB of the address space is a window of special registers in 32-byte blocks. Blocks marked as unimplemented read back as zero and ignore writes. A near-direct request only uses the low 13 address bits.

The control is a three-state machine:

- `ST_IDLE` accepts a request.
- `ST_RDATA` presents read data, one cycle after a read is accepted.
- `ST_TRAP` is the single cycle in which the trap pulse is high.

Its transitions are:

- idle-to-rdata on any read.
- idle-to-trap on a misaligned write.
- idle-to-idle on a good write or with no request.
- rdata-to-trap on a misaligned read.
- rdata-to-idle on an aligned read.
- trap-to-idle always.

Top module: `bwmem_access_unit`

## Requirements
- R1: A byte read fetches the whole word and places the selected byte on bits 7:0 of the result. Address bit 0 = 0 selects the low lane (word bits 7:0) and bit 0 = 1 selects the high lane (word bits 15:8).
- R2: A byte write raises only the strobe of the lane matching address bit 0 (mem_we bit 0 = low lane, bit 1 = high lane). It takes its data from req_wdata[7:0], and the other byte of the word keeps its value.
- R3: An aligned word write raises both strobes, with the byte at the even address in bits 7:0. An aligned word read returns {byte at address+1, byte at address}.
- R4: A word read at an odd address still returns the word holding that address, with rsp_valid one cycle after acceptance. trap_pulse follows in the next cycle.
- R5: A word write at an odd address raises no strobe and leaves memory unchanged. trap_pulse is high in the cycle after acceptance.
- R6: ptr_next equals the effective address plus 1 for a byte request and plus 2 for a word request, wrapping at 16 bits.
- R7: For a byte load, req_ext selects how the upper byte is filled. 0 keeps dest_old[15:8], 1 clears it, 2 copies bit 7 of the loaded byte, and 3 behaves as 0. A word load ignores dest_old.
- R8: Addresses below 0x0800 fall in 32-byte blocks. A block whose bit in SFR_MAP is 0 reads as zero and ignores writes. By default only the blocks at 0x0020 and 0x0060 are unimplemented.
- R9: With req_near set, the effective address is req_addr with bits 15:13 cleared.
- R10: trap_pulse lasts exactly one cycle. On a trap with no fault held, fault_addr loads the faulting effective address and fault_held sets. Both hold through later traps until fault_clear.
- R11: After reset, req_ready is 1 and rsp_valid, trap_pulse and fault_held are 0. req_ready is 0 outside ST_IDLE, and a request offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte, 0 = word |
| req_near | input | 1 | Use only the 13-bit near address field |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ext | input | 2 | Byte-load extension mode |
| dest_old | input | 16 | Current destination register value |
| ptr_next | output | 16 | Post-incremented pointer |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | 16 | Merged read result |
| mem_en | output | 1 | RAM access enable |
| mem_word_addr | output | 15 | RAM word address |
| mem_we | output | 2 | Per-lane write strobes |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after mem_en |
| trap_pulse | output | 1 | Address-error trap pulse |
| fault_clear | input | 1 | Clear captured fault |
| fault_addr | output | 16 | Captured faulting address |
| fault_held | output | 1 | A fault is captured |

## Verification
ptr_next and the write strobes are combinational from the request. They are sampled in the same cycle the request is driven, before the clock edge.

Read data and rsp_valid are due one cycle after acceptance. trap_pulse is due one cycle after a misaligned write and two cycles after a misaligned read. The bench samples each result at the falling edge of exactly that cycle. It then checks that the pulse has dropped in the cycle after.

Memory contents are compared with a byte-array model one cycle after a write. The captured fault address is read at the ports after the trap cycle.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

    typedef enum logic [1:0] {
        EXT_KEEP = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_SIGN = 2'd2,
        EXT_RSVD = 2'd3
    } ext_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_TRAP  = 2'd2
    } acc_state_e;

endpackage

// File: rtl/bwmem_addr_check.sv
module bwmem_addr_check #(
    parameter int ADDR_W    = 16,
    parameter int NEAR_W    = 13,
    parameter int SFR_BYTES = 2048,
    parameter int SFR_BLK   = 32,
    parameter int LSEL_W    = 1,
    parameter logic [SFR_BYTES/SFR_BLK-1:0] SFR_MAP = '1
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              near_mode,
    input  logic              is_byte,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] ptr_inc,
    output logic              misaligned,
    output logic              unimpl_sfr
);
    localparam int SFR_AW = $clog2(SFR_BYTES);
    localparam int BLK_AW = $clog2(SFR_BLK);

    // Near-field masking only exists when the field is narrower than the bus.
    generate
        if (NEAR_W < ADDR_W) begin : g_near_mask
            localparam logic [ADDR_W-1:0] NEAR_MASK =
                {{(ADDR_W-NEAR_W){1'b0}}, {NEAR_W{1'b1}}};
            assign eff_addr = near_mode ? (raw_addr & NEAR_MASK) : raw_addr;
        end else begin : g_no_mask
            assign eff_addr = raw_addr;
        end
    endgenerate

    logic                     in_sfr;
    logic [SFR_AW-BLK_AW-1:0] blk_idx;

    always_comb begin
        in_sfr     = (eff_addr >> SFR_AW) == '0;
        blk_idx    = eff_addr[SFR_AW-1:BLK_AW];
        unimpl_sfr = in_sfr && !SFR_MAP[blk_idx];
        misaligned = !is_byte && (eff_addr[LSEL_W-1:0] != '0);
        ptr_inc    = eff_addr + (is_byte ? ADDR_W'(1) : ADDR_W'(1 << LSEL_W));
    end
endmodule

// File: rtl/bwmem_lane_steer.sv
module bwmem_lane_steer
    import bwmem_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int NLANE  = DATA_W / LANE_W,
    parameter int LSEL_W = $clog2(NLANE)
) (
    // write side
    input  logic              wr_go,
    input  logic              wr_byte,
    input  logic [LSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NLANE-1:0]  lane_we,
    output logic [DATA_W-1:0] lane_wdata,
    // read side
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rd_zero,
    input  logic              rd_byte,
    input  logic [LSEL_W-1:0] rd_sel,
    input  ext_mode_e         rd_ext,
    input  logic [DATA_W-1:0] rd_dest,
    output logic [DATA_W-1:0] wb_data
);
    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            assign lane_we[g] = wr_go && (!wr_byte || (wr_sel == LSEL_W'(g)));
            assign lane_wdata[g*LANE_W +: LANE_W] =
                wr_byte ? wr_data[LANE_W-1:0] : wr_data[g*LANE_W +: LANE_W];
        end
    endgenerate

    logic [DATA_W-1:0] word_in;
    logic [LANE_W-1:0] picked;

    always_comb begin
        word_in = rd_zero ? '0 : rd_word;
        picked  = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (rd_sel == LSEL_W'(i)) picked = word_in[i*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        if (!rd_byte) begin
            wb_data = word_in;
        end else begin
            unique case (rd_ext)
                EXT_ZERO: wb_data = {{(DATA_W-LANE_W){1'b0}}, picked};
                EXT_SIGN: wb_data = {{(DATA_W-LANE_W){picked[LANE_W-1]}}, picked};
                EXT_KEEP,
                EXT_RSVD: wb_data = {rd_dest[DATA_W-1:LANE_W], picked};
                default:  wb_data = {rd_dest[DATA_W-1:LANE_W], picked};
            endcase
        end
    end
endmodule

// File: rtl/bwmem_fault_capture.sv
module bwmem_fault_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_fire,
    input  logic [ADDR_W-1:0] trap_ea,
    input  logic              clear,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr <= '0;
            fault_held <= 1'b0;
        end else if (trap_fire && !fault_held) begin
            fault_addr <= trap_ea;
            fault_held <= 1'b1;
        end else if (clear) begin
            fault_held <= 1'b0;
        end
    end

    // R10: a held fault keeps its address until cleared
    a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fault_held && !clear |=> fault_held && $stable(fault_addr));

    // R10: first fault is captured
    a_r10_fault_loads: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire && !fault_held |=> fault_held && (fault_addr == $past(trap_ea)));
endmodule

// File: rtl/bwmem_access_unit.sv
module bwmem_access_unit
    import bwmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int LANE_W    = 8,
    parameter int NEAR_W    = 13,
    parameter int SFR_BYTES = 2048,
    parameter int SFR_BLK   = 32,
    parameter logic [SFR_BYTES/SFR_BLK-1:0] SFR_MAP = 64'hFFFF_FFFF_FFFF_FFF5,
    localparam int NLANE  = DATA_W / LANE_W,
    localparam int LSEL_W = $clog2(NLANE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_byte,
    input  logic                req_near,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [1:0]          req_ext,
    input  logic [DATA_W-1:0]   dest_old,
    output logic [ADDR_W-1:0]   ptr_next,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                mem_en,
    output logic [ADDR_W-LSEL_W-1:0] mem_word_addr,
    output logic [NLANE-1:0]    mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                trap_pulse,
    input  logic                fault_clear,
    output logic [ADDR_W-1:0]   fault_addr,
    output logic                fault_held
);
    acc_state_e state_q, state_d;

    logic [ADDR_W-1:0] ea;
    logic              mis;
    logic              unimpl;
    logic              accept;
    logic              wr_go;

    // latched request fields for the data and trap phases
    logic              l_byte;
    logic              l_mis;
    logic              l_unimpl;
    logic [LSEL_W-1:0] l_sel;
    ext_mode_e         l_ext;
    logic [DATA_W-1:0] l_dest;
    logic [ADDR_W-1:0] l_ea;

    bwmem_addr_check #(
        .ADDR_W(ADDR_W), .NEAR_W(NEAR_W), .SFR_BYTES(SFR_BYTES),
        .SFR_BLK(SFR_BLK), .LSEL_W(LSEL_W), .SFR_MAP(SFR_MAP)
    ) u_addr (
        .raw_addr  (req_addr),
        .near_mode (req_near),
        .is_byte   (req_byte),
        .eff_addr  (ea),
        .ptr_inc   (ptr_next),
        .misaligned(mis),
        .unimpl_sfr(unimpl)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign wr_go  = accept && req_write && !mis && !unimpl;

    bwmem_lane_steer #(
        .DATA_W(DATA_W), .LANE_W(LANE_W), .NLANE(NLANE), .LSEL_W(LSEL_W)
    ) u_steer (
        .wr_go     (wr_go),
        .wr_byte   (req_byte),
        .wr_sel    (ea[LSEL_W-1:0]),
        .wr_data   (req_wdata),
        .lane_we   (mem_we),
        .lane_wdata(mem_wdata),
        .rd_word   (mem_rdata),
        .rd_zero   (l_unimpl),
        .rd_byte   (l_byte),
        .rd_sel    (l_sel),
        .rd_ext    (l_ext),
        .rd_dest   (l_dest),
        .wb_data   (rsp_data)
    );

    bwmem_fault_capture #(.ADDR_W(ADDR_W)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_fire (trap_pulse),
        .trap_ea   (l_ea),
        .clear     (fault_clear),
        .fault_addr(fault_addr),
        .fault_held(fault_held)
    );

    assign mem_en        = accept && (!req_write || wr_go);
    assign mem_word_addr = ea[ADDR_W-1:LSEL_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) state_d = ST_RDATA;
                    else if (mis)   state_d = ST_TRAP;
                    else            state_d = ST_IDLE;
                end
            end
            ST_RDATA: state_d = l_mis ? ST_TRAP : ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        trap_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready  = 1'b1;
            ST_RDATA: rsp_valid  = 1'b1;
            ST_TRAP:  trap_pulse = 1'b1;
            default:  req_ready  = 1'b0;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_byte   <= 1'b0;
            l_mis    <= 1'b0;
            l_unimpl <= 1'b0;
            l_sel    <= '0;
            l_ext    <= EXT_KEEP;
            l_dest   <= '0;
            l_ea     <= '0;
        end else if (accept) begin
            l_byte   <= req_byte;
            l_mis    <= mis;
            l_unimpl <= unimpl;
            l_sel    <= ea[LSEL_W-1:0];
            l_ext    <= ext_mode_e'(req_ext);
            l_dest   <= dest_old;
            l_ea     <= ea;
        end
    end

    // R2: a byte write touches at most one lane
    a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_byte |-> $onehot0(mem_we));

    // R5: misaligned word write raises no strobe and traps next cycle
    a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && mis |-> mem_we == '0);
    a_r5_trap_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && mis |=> trap_pulse);

    // R4: misaligned read returns data before the trap
    a_r4_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write && mis |=> rsp_valid && !trap_pulse);
    a_r4_trap_after: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && l_mis |=> trap_pulse);

    // R10: trap is a single-cycle pulse
    a_r10_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse);

    // R11: no request accepted while busy
    a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !mem_en);
endmodule

// File: tb/bwmem_access_unit_tb.sv
module bwmem_access_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MAP = 64'hFFFF_FFFF_FFFF_FFF5;

    typedef struct packed {
        logic        wr;
        logic        byt;
        logic        near;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  ext;
        logic [15:0] dest;
        logic        exp_trap;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b0, 1'b0, 16'h0900, 16'hA1B2, 2'd0, 16'h0000, 1'b0}, // R3 word write
        '{1'b0, 1'b0, 1'b0, 16'h0900, 16'h0000, 2'd0, 16'h0000, 1'b0}, // R3 word read
        '{1'b1, 1'b1, 1'b0, 16'h0903, 16'h5577, 2'd0, 16'h0000, 1'b0}, // R2 high lane
        '{1'b1, 1'b1, 1'b0, 16'h0902, 16'h1288, 2'd0, 16'h0000, 1'b0}, // R2 low lane
        '{1'b0, 1'b1, 1'b0, 16'h0903, 16'h0000, 2'd0, 16'hCAFE, 1'b0}, // R1 R7 keep
        '{1'b0, 1'b1, 1'b0, 16'h0902, 16'h0000, 2'd2, 16'h1234, 1'b0}, // R7 sign
        '{1'b0, 1'b1, 1'b0, 16'h0902, 16'h0000, 2'd1, 16'hFFFF, 1'b0}, // R7 zero
        '{1'b1, 1'b0, 1'b0, 16'h0905, 16'hDEAD, 2'd0, 16'h0000, 1'b1}, // R5
        '{1'b0, 1'b0, 1'b0, 16'h0903, 16'h0000, 2'd0, 16'h0000, 1'b1}, // R4
        '{1'b0, 1'b1, 1'b0, 16'h0901, 16'h0000, 2'd3, 16'h5500, 1'b0}, // R7 mode 3
        '{1'b1, 1'b0, 1'b1, 16'hE904, 16'h3C4D, 2'd0, 16'h0000, 1'b0}, // R9 write
        '{1'b0, 1'b0, 1'b1, 16'hF904, 16'h0000, 2'd0, 16'h0000, 1'b0}, // R9 read
        '{1'b1, 1'b0, 1'b0, 16'h0024, 16'h9999, 2'd0, 16'h0000, 1'b0}, // R8 write
        '{1'b0, 1'b0, 1'b0, 16'h0024, 16'h0000, 2'd0, 16'h0000, 1'b0}, // R8 read
        '{1'b0, 1'b1, 1'b0, 16'h0061, 16'h0000, 2'd0, 16'hAB11, 1'b0}, // R8 byte
        '{1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 2'd0, 16'h0000, 1'b0}  // R3 impl SFR
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_near = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, dest_old = '0;
    logic [1:0]  req_ext = '0;
    logic        fault_clear = 1'b0;
    logic        req_ready, rsp_valid, mem_en, trap_pulse, fault_held;
    logic [15:0] ptr_next, rsp_data, mem_wdata, fault_addr;
    logic [15:0] mem_rdata;
    logic [14:0] mem_word_addr;
    logic [1:0]  mem_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] ram     [0:4095];
    logic [7:0] ref_mem [0:4095];

    always #(CLK_PERIOD/2) clk = ~clk;

    bwmem_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_near(req_near),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ext(req_ext),
        .dest_old(dest_old), .ptr_next(ptr_next), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_en(mem_en), .mem_word_addr(mem_word_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .trap_pulse(trap_pulse), .fault_clear(fault_clear),
        .fault_addr(fault_addr), .fault_held(fault_held)
    );

    // RAM model: two byte lanes, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) ram[i] <= 8'(i * 37 + 5);
            mem_rdata <= '0;
        end else if (mem_en) begin
            mem_rdata <= {ram[{mem_word_addr[10:0], 1'b1}], ram[{mem_word_addr[10:0], 1'b0}]};
            if (mem_we[0]) ram[{mem_word_addr[10:0], 1'b0}] <= mem_wdata[7:0];
            if (mem_we[1]) ram[{mem_word_addr[10:0], 1'b1}] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] eff(input vec_t v);
        return v.near ? (v.addr & 16'h1FFF) : v.addr;
    endfunction

    function automatic bit is_unimpl(input logic [15:0] a);
        return (a < 16'h0800) && !MAP[a[10:5]];
    endfunction

    function automatic logic [15:0] exp_read(input vec_t v);
        logic [15:0] a, raw;
        logic [7:0]  b;
        a = eff(v);
        raw = is_unimpl(a) ? 16'h0000
                           : {ref_mem[{a[11:1], 1'b1}], ref_mem[{a[11:1], 1'b0}]};
        if (!v.byt) return raw;
        b = a[0] ? raw[15:8] : raw[7:0];
        case (v.ext)
            2'd1:    return {8'h00, b};
            2'd2:    return {{8{b[7]}}, b};
            default: return {v.dest[15:8], b};
        endcase
    endfunction

    task automatic do_op(input vec_t v, input int idx);
        logic [15:0] a, expd;
        logic [1:0]  exp_we;
        string tag;
        a = eff(v);
        expd = exp_read(v);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_byte = v.byt; req_near = v.near;
        req_addr = v.addr; req_wdata = v.wdata; req_ext = v.ext; dest_old = v.dest;
        #1;
        chk($sformatf("R6 ptr_next vec%0d", idx), 32'(ptr_next),
            32'(a + (v.byt ? 16'd1 : 16'd2)));
        if (v.wr) begin
            if (v.exp_trap || is_unimpl(a)) exp_we = 2'b00;
            else if (v.byt) exp_we = a[0] ? 2'b10 : 2'b01;
            else exp_we = 2'b11;
            tag = v.exp_trap ? "R5" : (is_unimpl(a) ? "R8" : (v.byt ? "R2" : "R3"));
            chk($sformatf("%s strobes vec%0d", tag, idx), 32'(mem_we), 32'(exp_we));
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (v.wr) begin
            chk($sformatf("R5 trap timing vec%0d", idx), 32'(trap_pulse), 32'(v.exp_trap));
            if (!v.exp_trap && !is_unimpl(a)) begin
                if (v.byt) ref_mem[a[11:0]] = v.wdata[7:0];
                else begin
                    ref_mem[{a[11:1], 1'b0}] = v.wdata[7:0];
                    ref_mem[{a[11:1], 1'b1}] = v.wdata[15:8];
                end
            end
            @(negedge clk);
            chk($sformatf("R10 trap dropped vec%0d", idx), 32'(trap_pulse), 32'd0);
            tag = v.exp_trap ? "R5" : (is_unimpl(a) ? "R8" : (v.byt ? "R2" : "R3"));
            chk($sformatf("%s memory lo vec%0d", tag, idx),
                32'(ram[{a[11:1], 1'b0}]), 32'(ref_mem[{a[11:1], 1'b0}]));
            chk($sformatf("%s memory hi vec%0d", tag, idx),
                32'(ram[{a[11:1], 1'b1}]), 32'(ref_mem[{a[11:1], 1'b1}]));
        end else begin
            tag = v.exp_trap ? "R4" : (is_unimpl(a) ? "R8" : (v.near ? "R9" : (v.byt ? "R1/R7" : "R3")));
            chk($sformatf("%s rsp_valid vec%0d", tag, idx), 32'(rsp_valid), 32'd1);
            chk($sformatf("%s rsp_data vec%0d", tag, idx), 32'(rsp_data), 32'(expd));
            chk($sformatf("R4 no early trap vec%0d", idx), 32'(trap_pulse), 32'd0);
            @(negedge clk);
            chk($sformatf("R4 trap after data vec%0d", idx), 32'(trap_pulse), 32'(v.exp_trap));
            if (v.exp_trap) begin
                @(negedge clk);
                chk($sformatf("R10 trap one cycle vec%0d", idx), 32'(trap_pulse), 32'd0);
            end
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'(i * 37 + 5);
        #(CLK_PERIOD * 3);
        // R11: reset state
        chk("R11 ready in reset", 32'(req_ready), 32'd1);
        chk("R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R11 trap in reset", 32'(trap_pulse), 32'd0);
        chk("R11 fault_held in reset", 32'(fault_held), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            do_op(VECS[k], k);
            if (k == 7) begin
                chk("R10 fault captured", 32'(fault_addr), 32'h0905);
                chk("R10 fault held", 32'(fault_held), 32'd1);
            end
        end

        // R10: later fault did not overwrite
        chk("R10 first fault kept", 32'(fault_addr), 32'h0905);
        @(negedge clk);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        chk("R10 fault cleared", 32'(fault_held), 32'd0);
        do_op('{1'b0, 1'b0, 1'b0, 16'h0907, 16'h0, 2'd0, 16'h0, 1'b1}, 100);
        chk("R10 new fault captured", 32'(fault_addr), 32'h0907);

        // R11: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_near = 1'b0;
        req_addr = 16'h0908;
        @(negedge clk);
        chk("R11 busy ready low", 32'(req_ready), 32'd0);
        req_write = 1'b1; req_addr = 16'h090A; req_wdata = 16'h6666;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 busy write ignored lo", 32'(ram[12'h90A]), 32'(ref_mem[12'h90A]));
        chk("R11 busy write ignored hi", 32'(ram[12'h90B]), 32'(ref_mem[12'h90B]));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule